// File: doc/BRIEF.md
# Vacuum Fluorescent Display Scan Controller

This block refreshes a multiplexed fluorescent display panel on its own, with no processor work per refresh. Software sets three values through a small configuration write port: the digit count, the segment count and a brightness code. Each digit has a time slot. During a slot the block lights that digit's strobe and drives the digit's segment pattern, which it has read from display RAM during the slot before.

One pool of output pins serves both functions. Digit strobes take the lowest pins. Segment lines take the pins directly above them. When the requested counts do not fit in the pool, the digit count is kept and the segment count is cut to what is left. Pins that the display does not claim drive the general-purpose output latch value given for each pin. Each frame opens with a key-scan slot. In this slot all digit strobes are off, the segment pins carry the latch values so a key matrix can be sensed, and a one-cycle interrupt pulse is raised. A brightness code shortens the lit part of every digit slot and leaves the rest of the slot dark.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: After reset the configuration is 2 digits, 9 segments and brightness 7. Scanning starts with a key-scan slot, so `key_irq` is high in the first cycle after reset.
- R2: A write with `cfg_wr` clamps the digit count to the range 2 to 16 and the segment count to the range 9 to 24.
- R3: Digit d drives pin d, for d from 0 to D-1. Segment k drives pin D+k. The segment count in use is S = min(clamped request, 34-D).
- R4: A frame is the key-scan slot followed by the digit slots 0 to D-1 in ascending order. Each slot has 8 sub-periods of `SUB_CYC` clocks. Digit pin d can be high only during slot d.
- R5: With brightness code b (0 to 7), the digit strobe and the segment lines are active in sub-periods 0 to b of a digit slot and low in every later sub-period.
- R6: In slot d, segment k carries bit k mod 8 of display RAM byte d*ceil(S/8) + k div 8.
- R7: Every pin at index D+S or higher follows `port_latch` for that pin, in the same cycle.
- R8: During the key-scan slot all digit pins are low and each segment pin follows its `port_latch` bit. `key_irq` is high only in the first clock cycle of the slot.
- R9: Display RAM is read through `ram_re`/`ram_addr`, with data on `ram_rdata` one cycle later. The address always stays below the RAM depth of 48 bytes.
- R10: A configuration write restarts the scan. The cycle after the write is the first cycle of a key-scan slot, even when the write arrives in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the three configuration fields |
| cfg_digits | input | 6 | Requested digit count |
| cfg_segs | input | 6 | Requested segment count |
| cfg_bright | input | 3 | Brightness code, number of lit sub-periods minus one |
| port_latch | input | 34 | General-purpose output latch value for each pin |
| ram_re | output | 1 | Display RAM read enable |
| ram_addr | output | 6 | Display RAM byte address |
| ram_rdata | input | 8 | Display RAM read data, valid one cycle after `ram_re` |
| pin_out | output | 34 | Shared digit/segment/port output pins |
| key_irq | output | 1 | Pulse at the start of each key-scan slot |

## Verification
The bench builds the block with `SUB_CYC` = 1. A slot is then 8 clocks and a 16-digit frame is 136 clocks. Many complete frames fit in a short run, and each sub-period lines up with a single clock, so the boundary at every brightness code is visible exactly. The other parameters keep their defaults: 34 pins, a 48-byte RAM, 2 to 16 digits and 9 to 24 segments. These defaults make the trimming case reachable (16 digits leave room for 18 segments, which needs three RAM bytes per digit and reaches RAM address 47), as are both clamp limits and the spare pins above a narrow configuration.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    localparam int CNT_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0] digits;
        logic [CNT_W-1:0] segs;
        logic [2:0]       bright;
        logic [CNT_W-1:0] bpd;
    } vfd_cfg_t;

    typedef struct packed {
        logic             key;
        logic [CNT_W-1:0] slot;
    } scan_pos_t;

    function automatic logic [CNT_W-1:0] clamp_cnt(
        input logic [CNT_W-1:0] v,
        input logic [CNT_W-1:0] lo,
        input logic [CNT_W-1:0] hi
    );
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] bytes_for(input logic [CNT_W-1:0] segs);
        logic [CNT_W:0] s;
        s = {1'b0, segs} + (CNT_W+1)'(7);
        return CNT_W'(s >> 3);
    endfunction

endpackage

// File: rtl/vfd_cfg_regs.sv
module vfd_cfg_regs
    import vfd_pkg::*;
#(
    parameter int NUM_PINS = 34,
    parameter int DIG_MIN  = 2,
    parameter int DIG_MAX  = 16,
    parameter int SEG_MIN  = 9,
    parameter int SEG_MAX  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] dig_in,
    input  logic [CNT_W-1:0] seg_in,
    input  logic [2:0]       bright_in,
    output vfd_cfg_t         cfg
);

    localparam logic [CNT_W-1:0] PINS_C = CNT_W'(NUM_PINS);
    localparam logic [CNT_W-1:0] DMIN_C = CNT_W'(DIG_MIN);
    localparam logic [CNT_W-1:0] DMAX_C = CNT_W'(DIG_MAX);
    localparam logic [CNT_W-1:0] SMIN_C = CNT_W'(SEG_MIN);
    localparam logic [CNT_W-1:0] SMAX_C = CNT_W'(SEG_MAX);
    localparam int RST_SEGS = (SEG_MIN > NUM_PINS - DIG_MIN) ? NUM_PINS - DIG_MIN : SEG_MIN;

    vfd_cfg_t         nxt_cfg;
    vfd_cfg_t         rst_cfg;
    logic [CNT_W-1:0] d_c, s_c, room, s_fit;

    always_comb begin
        d_c   = clamp_cnt(dig_in, DMIN_C, DMAX_C);
        s_c   = clamp_cnt(seg_in, SMIN_C, SMAX_C);
        room  = PINS_C - d_c;
        // digit count wins when the pool is too small
        s_fit = (s_c > room) ? room : s_c;
        nxt_cfg.digits = d_c;
        nxt_cfg.segs   = s_fit;
        nxt_cfg.bright = bright_in;
        nxt_cfg.bpd    = bytes_for(s_fit);

        rst_cfg.digits = DMIN_C;
        rst_cfg.segs   = CNT_W'(RST_SEGS);
        rst_cfg.bright = 3'd7;
        rst_cfg.bpd    = bytes_for(CNT_W'(RST_SEGS));
    end

    always_ff @(posedge clk) begin
        if (rst)     cfg <= rst_cfg;
        else if (wr) cfg <= nxt_cfg;
    end

endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
    import vfd_pkg::*;
#(
    parameter int SUB_CYC = 4,
    parameter int SLOT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CNT_W-1:0]  digits,
    output scan_pos_t         pos,
    output logic [SLOT_W-1:0] cnt,
    output logic [2:0]        sub,
    output logic              slot_last
);

    localparam int SLOT_LEN = 8 * SUB_CYC;

    always_comb begin
        slot_last = (cnt == SLOT_W'(SLOT_LEN - 1));
        sub       = 3'(int'(cnt) / SUB_CYC);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos.key  <= 1'b1;
            pos.slot <= '0;
            cnt      <= '0;
        end else if (slot_last) begin
            cnt <= '0;
            if (pos.key) begin
                pos.key  <= 1'b0;
                pos.slot <= '0;
            end else if (pos.slot == digits - 1'b1) begin
                pos.key <= 1'b1;
            end else begin
                pos.slot <= pos.slot + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vfd_seg_fetch.sv
module vfd_seg_fetch
    import vfd_pkg::*;
#(
    parameter int SEG_MAX = 24,
    parameter int SLOT_W  = 5,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [CNT_W-1:0]   digits,
    input  logic [CNT_W-1:0]   bpd,
    input  scan_pos_t          pos,
    input  logic [SLOT_W-1:0]  cnt,
    input  logic               slot_last,
    output logic               ram_re,
    output logic [ADDR_W-1:0]  ram_addr,
    input  logic [7:0]         ram_rdata,
    output logic [SEG_MAX-1:0] seg_bits
);

    localparam int MAX_BYTES = (SEG_MAX + 7) / 8;
    localparam int BYTE_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic [7:0]             stage [MAX_BYTES];
    logic [8*MAX_BYTES-1:0] flat;
    logic                   need;
    logic [CNT_W-1:0]       nxt_digit;
    logic                   cap_v;
    logic [BYTE_W-1:0]      cap_idx;
    int                     addr_i;

    always_comb begin
        // the slot that follows needs a pattern unless it is the key-scan slot
        need      = pos.key || (pos.slot != digits - 1'b1);
        nxt_digit = pos.key ? '0 : pos.slot + 1'b1;
        ram_re    = need && (int'(cnt) < int'(bpd));
        addr_i    = int'(nxt_digit) * int'(bpd) + int'(cnt);
        ram_addr  = ADDR_W'(addr_i);
        for (int j = 0; j < MAX_BYTES; j++) flat[8*j +: 8] = stage[j];
    end

    always_ff @(posedge clk) begin
        if (cap_v) stage[cap_idx] <= ram_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cap_v    <= 1'b0;
            cap_idx  <= '0;
            seg_bits <= '0;
        end else begin
            cap_v   <= ram_re;
            cap_idx <= BYTE_W'(cnt);
            if (slot_last) seg_bits <= flat[SEG_MAX-1:0];
        end
    end

endmodule

// File: rtl/vfd_pin_mux.sv
module vfd_pin_mux
    import vfd_pkg::*;
#(
    parameter int NUM_PINS = 34,
    parameter int SEG_MAX  = 24
) (
    input  logic [CNT_W-1:0]    digits,
    input  logic [CNT_W-1:0]    segs,
    input  logic [2:0]          bright,
    input  scan_pos_t           pos,
    input  logic [2:0]          sub,
    input  logic [SEG_MAX-1:0]  seg_bits,
    input  logic [NUM_PINS-1:0] port_latch,
    output logic [NUM_PINS-1:0] pins
);

    logic                lit;
    logic [NUM_PINS-1:0] seg_pad;
    logic [CNT_W-1:0]    seg_top;

    always_comb begin
        lit     = !pos.key && (sub <= bright);
        seg_pad = NUM_PINS'(seg_bits);
        seg_top = digits + segs;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [CNT_W-1:0] PC = CNT_W'(p);
        logic [CNT_W-1:0] k;
        logic             v;
        always_comb begin
            k = PC - digits;
            if (PC < digits)
                v = lit && (pos.slot == PC);
            else if (PC < seg_top)
                v = pos.key ? port_latch[p] : (lit && seg_pad[k]);
            else
                v = port_latch[p];
        end
        assign pins[p] = v;
    end

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
    import vfd_pkg::*;
#(
    parameter int NUM_PINS  = 34,
    parameter int DIG_MIN   = 2,
    parameter int DIG_MAX   = 16,
    parameter int SEG_MIN   = 9,
    parameter int SEG_MAX   = 24,
    parameter int RAM_DEPTH = 48,
    parameter int SUB_CYC   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_wr,
    input  logic [CNT_W-1:0]             cfg_digits,
    input  logic [CNT_W-1:0]             cfg_segs,
    input  logic [2:0]                   cfg_bright,
    input  logic [NUM_PINS-1:0]          port_latch,
    output logic                         ram_re,
    output logic [$clog2(RAM_DEPTH)-1:0] ram_addr,
    input  logic [7:0]                   ram_rdata,
    output logic [NUM_PINS-1:0]          pin_out,
    output logic                         key_irq
);

    localparam int SLOT_W = $clog2(8 * SUB_CYC);
    localparam int ADDR_W = $clog2(RAM_DEPTH);

    vfd_cfg_t           cfg_q;
    scan_pos_t          pos;
    logic [SLOT_W-1:0]  cnt;
    logic [2:0]         sub;
    logic               slot_last;
    logic [SEG_MAX-1:0] seg_bits;
    logic [CNT_W-1:0]   dig_q;

    assign dig_q   = cfg_q.digits;
    assign key_irq = pos.key && (cnt == '0);

    vfd_cfg_regs #(
        .NUM_PINS(NUM_PINS), .DIG_MIN(DIG_MIN), .DIG_MAX(DIG_MAX),
        .SEG_MIN(SEG_MIN), .SEG_MAX(SEG_MAX)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr),
        .dig_in(cfg_digits), .seg_in(cfg_segs), .bright_in(cfg_bright),
        .cfg(cfg_q)
    );

    vfd_scan_timer #(.SUB_CYC(SUB_CYC), .SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(cfg_wr), .digits(cfg_q.digits),
        .pos(pos), .cnt(cnt), .sub(sub), .slot_last(slot_last)
    );

    vfd_seg_fetch #(.SEG_MAX(SEG_MAX), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst(rst), .restart(cfg_wr),
        .digits(cfg_q.digits), .bpd(cfg_q.bpd),
        .pos(pos), .cnt(cnt), .slot_last(slot_last),
        .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .seg_bits(seg_bits)
    );

    vfd_pin_mux #(.NUM_PINS(NUM_PINS), .SEG_MAX(SEG_MAX)) u_mux (
        .digits(cfg_q.digits), .segs(cfg_q.segs), .bright(cfg_q.bright),
        .pos(pos), .sub(sub), .seg_bits(seg_bits),
        .port_latch(port_latch), .pins(pin_out)
    );

endmodule

// File: rtl/vfd_scan_ctrl_chk.sv
module vfd_scan_ctrl_chk
    import vfd_pkg::*;
#(
    parameter int NUM_PINS  = 34,
    parameter int RAM_DEPTH = 48
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cfg_wr,
    input logic                         key_irq,
    input logic                         ram_re,
    input logic [$clog2(RAM_DEPTH)-1:0] ram_addr,
    input logic [NUM_PINS-1:0]          pin_out,
    input logic [CNT_W-1:0]             dig_q
);

    logic [NUM_PINS-1:0] dmask;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) dmask[i] = (i < int'(dig_q));
    end

    // R4: at most one digit strobe at a time
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pin_out & dmask));

    // R8: no digit strobe in the key-scan slot
    a_r8_strobes_off: assert property (@(posedge clk) disable iff (rst)
        key_irq |-> ((pin_out & dmask) == '0));

    // R8: key-scan interrupt lasts one cycle
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        (key_irq && !cfg_wr) |=> !key_irq);

    // R9: RAM address inside the display RAM
    a_r9_addr_range: assert property (@(posedge clk) disable iff (rst)
        ram_re |-> (int'(ram_addr) < RAM_DEPTH));

    // R10: a configuration write restarts at the key-scan slot
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> key_irq);

endmodule

bind vfd_scan_ctrl vfd_scan_ctrl_chk #(
    .NUM_PINS(NUM_PINS), .RAM_DEPTH(RAM_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .key_irq(key_irq),
    .ram_re(ram_re), .ram_addr(ram_addr), .pin_out(pin_out), .dig_q(dig_q)
);

// File: tb/vfd_scan_ctrl_test.sv
module vfd_scan_ctrl_test;

    localparam int SUB   = 1;
    localparam int PINS  = 34;
    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [5:0]  cfg_digits, cfg_segs;
    logic [2:0]  cfg_bright;
    logic [PINS-1:0] port_latch;
    logic        ram_re;
    logic [5:0]  ram_addr;
    logic [7:0]  ram_rdata;
    logic [PINS-1:0] pin_out;
    logic        key_irq;

    always #4 clk = ~clk;

    vfd_scan_ctrl #(.SUB_CYC(SUB)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
        .cfg_digits(cfg_digits), .cfg_segs(cfg_segs), .cfg_bright(cfg_bright),
        .port_latch(port_latch), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .pin_out(pin_out), .key_irq(key_irq)
    );

    logic [7:0] mem [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 53 + 11) % 256);

    always @(posedge clk) if (ram_re) ram_rdata <= mem[ram_addr];

    typedef struct {
        int    t;
        int    dq;
        int    sq;
        int    bq;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R1 reset state";
    int    t_m, md, ms, mb;
    bit    started = 1'b0;
    bit    done = 1'b0;

    // driver side of the scoreboard: one expected item per clock
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            t_m = 0; md = 2; ms = 9; mb = 7; started = 1'b1;
        end else if (cfg_wr) begin
            md = int'(cfg_digits); ms = int'(cfg_segs); mb = int'(cfg_bright); t_m = 0;
        end else begin
            t_m++;
        end
        if (started) begin
            e.t = t_m; e.dq = md; e.sq = ms; e.bq = mb; e.tag = cur_tag;
            sb.push_back(e);
        end
    end

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [PINS-1:0] model_pins(exp_t e, logic [PINS-1:0] pl);
        logic [PINS-1:0] r;
        int d_n, s_n, b_n, q, c, s, dg, sub;
        bit key, act;
        d_n = clampi(e.dq, 2, 16);
        s_n = clampi(e.sq, 9, 24);
        if (s_n > PINS - d_n) s_n = PINS - d_n;
        b_n = (s_n + 7) / 8;
        q   = e.t / (8 * SUB);
        c   = e.t % (8 * SUB);
        s   = q % (d_n + 1);
        key = (s == 0);
        dg  = s - 1;
        sub = c / SUB;
        act = !key && (sub <= e.bq);
        for (int p = 0; p < PINS; p++) begin
            if (p < d_n) begin
                r[p] = act && (p == dg);
            end else if (p < d_n + s_n) begin
                int k;
                k = p - d_n;
                if (key) r[p] = pl[p];
                else     r[p] = act && mem[dg * b_n + k / 8][k % 8];
            end else begin
                r[p] = pl[p];
            end
        end
        return r;
    endfunction

    function automatic bit model_irq(exp_t e);
        int d_n;
        d_n = clampi(e.dq, 2, 16);
        return ((e.t / (8 * SUB)) % (d_n + 1) == 0) && (e.t % (8 * SUB) == 0);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #6;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, 64'(pin_out), 64'(model_pins(e, port_latch)));
                chk("R8 key_irq pulse", 64'(key_irq), 64'(model_irq(e)));
            end
            if (ram_re === 1'b1)
                chk("R9 ram_addr range", 64'(int'(ram_addr) < DEPTH), 64'(1));
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(int d, int s, int b, string tag);
        @(negedge clk);
        cfg_digits = 6'(d); cfg_segs = 6'(s); cfg_bright = 3'(b);
        cfg_wr = 1'b1; cur_tag = tag;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_digits = '0; cfg_segs = '0; cfg_bright = '0;
        port_latch = 34'h2_5A3C_9E71;
        run(3);
        rst = 1'b0;
        run(4);
        cur_tag = "R4 R6 default scan order and patterns";
        run(3 * 3 * 8);

        cfg_write(4, 12, 3, "R5 brightness 3 blanking");
        run(3 * 5 * 8);

        cfg_write(16, 24, 0, "R3 segment count trimmed to 18");
        run(2 * 17 * 8);

        cfg_write(1, 5, 5, "R2 low clamp to 2 digits 9 segments");
        run(2 * 3 * 8);

        cfg_write(40, 40, 6, "R2 high clamp to 16 digits");
        run(17 * 8 + 20);

        cfg_write(8, 24, 7, "R7 spare pins follow port latch");
        run(3);
        port_latch = 34'h1_0F0F_3366;
        run(20);
        port_latch = 34'h3_C3A5_0FF0;
        run(2 * 9 * 8);

        cfg_write(6, 10, 2, "R10 rewrite in the middle of a slot");
        run(13);
        cfg_write(5, 16, 4, "R10 restart after mid-slot rewrite");
        run(2 * 6 * 8);

        run(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule